// File: doc/BRIEF.md
# Isochronous IN Ping-Pong Endpoint Buffer

This block controls two packet banks for a single isochronous IN endpoint of a USB device. A streaming write port, fed by a DMA engine one byte per beat, fills one bank while the USB transaction layer sends the other. Each bank has a ready flag. The system side fills the banks in strict alternation, and the USB side sends them in the same order. The block keeps only the bookkeeping: which bank is being written, which bank is sent next, and how many bytes each one holds. The packet storage itself sits outside.

A bank closes in one of three ways: its byte count reaches the programmed maximum packet size; the DMA marks its last beat while automatic validation is on; or software pulses a validate strobe. An IN token that arrives while the next bank is ready produces a reply strobe. An IN token that finds no bank ready gets no reply at all. Instead it sets a sticky error status bit, which raises an interrupt only when the interrupt is enabled. For high-bandwidth use, a transaction counter is loaded with the number of packets and steps down by one for each bank that closes. Isochronous endpoints have no handshake, so the stall command input is accepted and has no effect.

Top module: `iso_in_pingpong`

## Requirements
- R1: After reset: wr_ready=1, wr_bank=0, tx_avail=0, tx_bank=0, resp_send=0, err_sts=0, irq=0 and xact_left=0.
- R2: Banks are filled in the order 0,1,0,1. wr_bank shows the bank being written (0 or 1) and changes in the cycle after that bank closes. tx_bank shows the bank that is sent next, and it follows the same order.
- R3: An accepted beat (wr_valid and wr_ready both 1) adds one byte to the current bank. When the count reaches cfg_max_pkt, the bank becomes ready in the next cycle, and tx_len equals that count.
- R4: When wr_last is set on an accepted beat and cfg_auto_val=1, the bank becomes ready holding its short byte count. When cfg_auto_val=0, wr_last does not close the bank. A sw_validate pulse closes the current bank with the bytes it holds.
- R5: While the bank at the write pointer is still ready, wr_ready=0. Beats offered during that time are not counted.
- R6: An in_token while tx_avail=1 gives a one-cycle resp_send pulse in the next cycle. A tx_done pulse while tx_avail=1 clears that bank's flag and moves tx_bank to the other bank.
- R7: An in_token while tx_avail=0 gives no resp_send, and err_sts is 1 in the next cycle.
- R8: irq equals err_sts AND cfg_irq_en.
- R9: err_sts stays at 1 until an err_clr pulse clears it. If a set and an err_clr occur in the same cycle, the bit stays at 1.
- R10: A stall_cmd pulse changes no ready flag, tx_len, wr_ready or err_sts.
- R11: xact_load loads xact_left from xact_num. Each bank close decrements xact_left by one, and xact_left holds at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_pkt | input | 11 | Maximum packet size in bytes (1..1024) |
| cfg_auto_val | input | 1 | Close the bank on a DMA last beat |
| cfg_irq_en | input | 1 | Interrupt enable for the no-bank error |
| sw_validate | input | 1 | Software strobe: close the current write bank |
| stall_cmd | input | 1 | Stall command, which is ignored |
| err_clr | input | 1 | Write-one-to-clear strobe for err_sts |
| xact_load | input | 1 | Load the transaction counter |
| xact_num | input | 8 | Transaction count to load |
| wr_valid | input | 1 | Write beat valid (one byte) |
| wr_last | input | 1 | Last beat of the DMA transfer |
| wr_ready | output | 1 | Write bank is free |
| wr_bank | output | 1 | Bank being written |
| in_token | input | 1 | IN token received |
| tx_done | input | 1 | USB side finished sending the bank |
| tx_avail | output | 1 | Next bank to send is ready |
| tx_bank | output | 1 | Next bank to send |
| tx_len | output | 16 | Byte count of the next bank |
| resp_send | output | 1 | Reply strobe for an accepted token |
| err_sts | output | 1 | Sticky no-bank error status |
| irq | output | 1 | Interrupt request |
| xact_left | output | 8 | Transactions remaining |

## Verification
The bench builds the block with a maximum packet size of 4 bytes and default widths. With a packet that small, reaching the size limit, filling both banks and the refused-write condition all take only a few beats each. A vector table runs four packets that close in each of the three ways and end on both banks. Loading a count of 3 against those four closes carries the transaction counter down to its zero floor.

// File: rtl/iso_pp_pkg.sv
package iso_pp_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned MPS_W  = 11;
  localparam int unsigned XACT_W = 8;
  localparam int unsigned NBANK  = 2;

  // Byte count after an optional accepted beat.
  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] n,
                                                   input logic beat);
    return beat ? n + 1'b1 : n;
  endfunction

  // A bank is full once its count reaches the maximum packet size.
  function automatic logic at_limit(input logic [CNT_W-1:0] n,
                                    input logic [MPS_W-1:0] mps);
    return n >= CNT_W'(mps);
  endfunction

  // Counter step toward zero, holding at zero.
  function automatic logic [XACT_W-1:0] step_down(input logic [XACT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction
endpackage

// File: rtl/iso_wr_side.sv
module iso_wr_side
  import iso_pp_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned MW = MPS_W,
  parameter int unsigned NB = NBANK
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [MW-1:0]              mps,
  input  logic                       auto_val,
  input  logic                       sw_validate,
  input  logic                       wr_valid,
  input  logic                       wr_last,
  input  logic                       bank_busy,
  output logic                       wr_ready,
  output logic [$clog2(NB)-1:0]      wr_ptr,
  output logic                       close_ev,
  output logic [CW-1:0]              close_len
);
  localparam int unsigned PW = $clog2(NB);

  logic [CW-1:0] cnt_q;
  logic          fire;
  logic [CW-1:0] cnt_nxt;
  logic          full_hit;
  logic          last_hit;

  assign wr_ready  = !bank_busy;
  assign fire      = wr_valid && wr_ready;
  assign cnt_nxt   = count_after(cnt_q, fire);
  assign full_hit  = fire && at_limit(cnt_nxt, mps);
  assign last_hit  = fire && wr_last && auto_val;
  assign close_ev  = !bank_busy && (full_hit || last_hit || sw_validate);
  assign close_len = cnt_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wr_ptr <= '0;
    end else if (close_ev) begin
      cnt_q  <= '0;
      wr_ptr <= (wr_ptr == PW'(NB - 1)) ? '0 : wr_ptr + 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
    end
  end

  AST_NO_WRITE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && bank_busy) |=> $stable(cnt_q)); // R5
  AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mps != '0) |-> (cnt_q < CW'(mps))); // R3
endmodule

// File: rtl/iso_bank_flags.sv
module iso_bank_flags
  import iso_pp_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned NB = NBANK
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  close_ev,
  input  logic [$clog2(NB)-1:0] wr_ptr,
  input  logic [CW-1:0]         close_len,
  input  logic                  clr_ev,
  input  logic [$clog2(NB)-1:0] rd_ptr,
  output logic [NB-1:0]         rdy,
  output logic [NB*CW-1:0]      len_flat
);
  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          set_b;
    logic          clr_b;
    logic [CW-1:0] len_q;

    assign set_b = close_ev && (wr_ptr == b);
    assign clr_b = clr_ev && (rd_ptr == b);
    assign len_flat[b*CW +: CW] = len_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy[b] <= 1'b0;
        len_q  <= '0;
      end else if (set_b) begin
        rdy[b] <= 1'b1;
        len_q  <= close_len;
      end else if (clr_b) begin
        rdy[b] <= 1'b0;
      end
    end

    AST_NO_DOUBLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      rdy[b] |-> !set_b); // R5
  end
endmodule

// File: rtl/iso_rd_side.sv
module iso_rd_side
  import iso_pp_pkg::*;
#(
  parameter int unsigned NB = NBANK
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_token,
  input  logic                  tx_done,
  input  logic                  avail,
  input  logic                  err_clr,
  output logic [$clog2(NB)-1:0] rd_ptr,
  output logic                  clr_ev,
  output logic                  nobank_ev,
  output logic                  resp_send,
  output logic                  err_sts
);
  localparam int unsigned PW = $clog2(NB);

  assign clr_ev    = tx_done && avail;
  assign nobank_ev = in_token && !avail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      resp_send <= 1'b0;
      err_sts   <= 1'b0;
    end else begin
      resp_send <= in_token && avail;
      if (clr_ev) rd_ptr <= (rd_ptr == PW'(NB - 1)) ? '0 : rd_ptr + 1'b1;
      if (nobank_ev)    err_sts <= 1'b1;
      else if (err_clr) err_sts <= 1'b0;
    end
  end

  AST_SILENT_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !avail) |=> !resp_send); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sts && !err_clr) |=> err_sts); // R9
  AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    nobank_ev |=> err_sts); // R7
endmodule

// File: rtl/iso_xact_cnt.sv
module iso_xact_cnt
  import iso_pp_pkg::*;
#(
  parameter int unsigned XW = XACT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [XW-1:0] num,
  input  logic          dec,
  output logic [XW-1:0] left
);
  always_ff @(posedge clk) begin
    if (!rst_n)   left <= '0;
    else if (load) left <= num;
    else if (dec)  left <= step_down(left);
  end

  AST_XACT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && left == '0) |=> (left == '0)); // R11
  AST_XACT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dec && left != '0) |=> (left == $past(left) - 1'b1)); // R11
endmodule

// File: rtl/iso_in_pingpong.sv
module iso_in_pingpong
  import iso_pp_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned MW = MPS_W,
  parameter int unsigned XW = XACT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] cfg_max_pkt,
  input  logic          cfg_auto_val,
  input  logic          cfg_irq_en,
  input  logic          sw_validate,
  input  logic          stall_cmd,
  input  logic          err_clr,
  input  logic          xact_load,
  input  logic [XW-1:0] xact_num,
  input  logic          wr_valid,
  input  logic          wr_last,
  output logic          wr_ready,
  output logic          wr_bank,
  input  logic          in_token,
  input  logic          tx_done,
  output logic          tx_avail,
  output logic          tx_bank,
  output logic [CW-1:0] tx_len,
  output logic          resp_send,
  output logic          err_sts,
  output logic          irq,
  output logic [XW-1:0] xact_left
);
  localparam int unsigned NB = NBANK;
  localparam int unsigned PW = $clog2(NB);

  logic [PW-1:0]    wr_ptr;
  logic [PW-1:0]    rd_ptr;
  logic [NB-1:0]    rdy;
  logic [NB*CW-1:0] len_flat;
  logic             close_ev;
  logic [CW-1:0]    close_len;
  logic             clr_ev;
  logic             nobank_ev;

  iso_wr_side #(.CW(CW), .MW(MW), .NB(NB)) u_wr (
    .clk(clk), .rst_n(rst_n), .mps(cfg_max_pkt), .auto_val(cfg_auto_val),
    .sw_validate(sw_validate), .wr_valid(wr_valid), .wr_last(wr_last),
    .bank_busy(rdy[wr_ptr]), .wr_ready(wr_ready), .wr_ptr(wr_ptr),
    .close_ev(close_ev), .close_len(close_len)
  );

  iso_bank_flags #(.CW(CW), .NB(NB)) u_flags (
    .clk(clk), .rst_n(rst_n), .close_ev(close_ev), .wr_ptr(wr_ptr),
    .close_len(close_len), .clr_ev(clr_ev), .rd_ptr(rd_ptr),
    .rdy(rdy), .len_flat(len_flat)
  );

  iso_rd_side #(.NB(NB)) u_rd (
    .clk(clk), .rst_n(rst_n), .in_token(in_token), .tx_done(tx_done),
    .avail(rdy[rd_ptr]), .err_clr(err_clr), .rd_ptr(rd_ptr),
    .clr_ev(clr_ev), .nobank_ev(nobank_ev), .resp_send(resp_send),
    .err_sts(err_sts)
  );

  iso_xact_cnt #(.XW(XW)) u_xact (
    .clk(clk), .rst_n(rst_n), .load(xact_load), .num(xact_num),
    .dec(close_ev), .left(xact_left)
  );

  assign wr_bank  = wr_ptr[0];
  assign tx_bank  = rd_ptr[0];
  assign tx_avail = rdy[rd_ptr];
  assign tx_len   = len_flat[rd_ptr*CW +: CW];
  assign irq      = err_sts && cfg_irq_en;

  AST_STALL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cmd && !wr_valid && !sw_validate && !tx_done && !in_token && !err_clr)
    |=> ($stable(rdy) && $stable(tx_len) && $stable(err_sts))); // R10
  AST_ORDER_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    close_ev |=> (wr_ptr != $past(wr_ptr))); // R2
  AST_TX_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    resp_send |-> $past(rdy[rd_ptr])); // R6
  AST_NOBANK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    nobank_ev |-> !tx_avail); // R7
endmodule

// File: tb/iso_in_pingpong_test.sv
module iso_in_pingpong_test;
  localparam int PERIOD = 10;
  localparam int MPS    = 4;
  localparam int NV     = 4;
  // Vector table: beats, last flag, auto-validate, software validate, expected length
  localparam int V_BEATS [NV] = '{4, 2, 3, 1};
  localparam int V_LAST  [NV] = '{0, 1, 1, 1};
  localparam int V_AUTO  [NV] = '{0, 1, 0, 1};
  localparam int V_SWV   [NV] = '{0, 0, 1, 0};
  localparam int V_LEN   [NV] = '{4, 2, 3, 1};
  localparam int XACT0   = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [10:0] cfg_max_pkt = 11'(MPS);
  logic cfg_auto_val = 0, cfg_irq_en = 0, sw_validate = 0, stall_cmd = 0;
  logic err_clr = 0, xact_load = 0, wr_valid = 0, wr_last = 0;
  logic in_token = 0, tx_done = 0;
  logic [7:0] xact_num = 0;
  logic wr_ready, wr_bank, tx_avail, tx_bank, resp_send, err_sts, irq;
  logic [15:0] tx_len;
  logic [7:0] xact_left;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  iso_in_pingpong uut (
    .clk(clk), .rst_n(rst_n), .cfg_max_pkt(cfg_max_pkt), .cfg_auto_val(cfg_auto_val),
    .cfg_irq_en(cfg_irq_en), .sw_validate(sw_validate), .stall_cmd(stall_cmd),
    .err_clr(err_clr), .xact_load(xact_load), .xact_num(xact_num),
    .wr_valid(wr_valid), .wr_last(wr_last), .wr_ready(wr_ready), .wr_bank(wr_bank),
    .in_token(in_token), .tx_done(tx_done), .tx_avail(tx_avail), .tx_bank(tx_bank),
    .tx_len(tx_len), .resp_send(resp_send), .err_sts(err_sts), .irq(irq),
    .xact_left(xact_left)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic beat(input logic last);
    @(negedge clk); wr_valid = 1; wr_last = last;
    @(negedge clk); wr_valid = 0; wr_last = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "wr_ready", int'(wr_ready), 1);
    check("R1", "wr_bank", int'(wr_bank), 0);
    check("R1", "tx_avail", int'(tx_avail), 0);
    check("R1", "tx_bank", int'(tx_bank), 0);
    check("R1", "resp_send", int'(resp_send), 0);
    check("R1", "err_sts", int'(err_sts), 0);
    check("R1", "irq", int'(irq), 0);
    check("R1", "xact_left", int'(xact_left), 0);

    xact_num = 8'(XACT0);
    pulse(xact_load);
    check("R11", "xact load", int'(xact_left), XACT0);

    // Table walk: each row closes one bank a different way
    for (int i = 0; i < NV; i++) begin
      cfg_auto_val = logic'(V_AUTO[i]);
      for (int k = 0; k < V_BEATS[i]; k++)
        beat(logic'(V_LAST[i] != 0 && k == V_BEATS[i] - 1));
      if (V_SWV[i] != 0) begin
        // R4: last without auto-validate leaves the bank open
        check("R4", "open after last", int'(tx_avail), 0);
        check("R4", "wr_bank held", int'(wr_bank), i % 2);
        pulse(sw_validate);
      end
      check("R3", "ready after close", int'(tx_avail), 1);
      check("R4", "tx_len", int'(tx_len), V_LEN[i]);
      check("R2", "tx_bank order", int'(tx_bank), i % 2);
      check("R2", "wr_bank advanced", int'(wr_bank), (i + 1) % 2);
      check("R11", "xact step", int'(xact_left), (XACT0 - (i + 1)) > 0 ? XACT0 - (i + 1) : 0);
      @(negedge clk); in_token = 1;
      @(negedge clk); in_token = 0;
      check("R6", "resp_send", int'(resp_send), 1);
      pulse(tx_done);
      check("R6", "flag cleared", int'(tx_avail), 0);
      check("R6", "tx_bank advanced", int'(tx_bank), (i + 1) % 2);
    end

    // R7/R8: token with no bank ready
    @(negedge clk); in_token = 1;
    @(negedge clk); in_token = 0;
    check("R7", "no reply", int'(resp_send), 0);
    check("R7", "err set", int'(err_sts), 1);
    check("R8", "irq masked", int'(irq), 0);
    cfg_irq_en = 1; #1;
    check("R8", "irq enabled", int'(irq), 1);
    pulse(err_clr);
    check("R9", "err cleared", int'(err_sts), 0);
    check("R8", "irq follows", int'(irq), 0);
    @(negedge clk); in_token = 1; err_clr = 1;
    @(negedge clk); in_token = 0; err_clr = 0;
    check("R9", "set wins", int'(err_sts), 1);
    @(negedge clk);
    check("R9", "sticky", int'(err_sts), 1);
    pulse(err_clr);

    // R5: both banks full, write refused
    cfg_auto_val = 0;
    for (int k = 0; k < 2 * MPS; k++) beat(1'b0);
    check("R5", "wr_ready low", int'(wr_ready), 0);
    beat(1'b0);
    beat(1'b0);
    // R10: stall has no effect
    pulse(stall_cmd);
    check("R10", "avail kept", int'(tx_avail), 1);
    check("R10", "len kept", int'(tx_len), MPS);
    check("R10", "wr_ready kept", int'(wr_ready), 0);
    check("R10", "err kept", int'(err_sts), 0);
    pulse(tx_done);
    check("R5", "wr_ready after free", int'(wr_ready), 1);
    cfg_auto_val = 1;
    beat(1'b1);
    pulse(tx_done);
    check("R5", "refused beats not counted", int'(tx_len), 1);
    check("R2", "bank 0 again", int'(tx_bank), 0);
    check("R11", "xact floor", int'(xact_left), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule